// File: doc/BRIEF.md
# Command-keyed watchdog timer

The block is a watchdog built on a 20-bit down-counter. The counter steps down by one on each pulse of a slow timebase tick enable, which is nominally 90 kHz and one system clock wide. Software drives the block through a small 32-bit register port that has two locations. A control location accepts only a fixed set of 16-bit command words: halt, run, acknowledge, open, seal and fill. A count location holds the reload value. Writes to the count location take effect only while the count is open. Reading the count location returns the upper 16 bits of the counter.

When the running counter reaches zero, the block sets a sticky interrupt. If software does not acknowledge the interrupt within a further 16 ticks, the block drives a system reset request for 32 clock cycles. It then refills the counter to full scale and drops the interrupt. To force a restart on purpose, software opens the count, writes a count of 1 and lets the counter run. Expiry then follows after 16 ticks.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the counter is stopped and the count is sealed. The counter holds all ones, so a read of offset 0x04 returns 0x0000FFFF. `wdt_irq` and `sys_rst_req` are low.
- R2: A write of 0x00003877 to offset 0x00 halts the counter, and a write of 0x00004A4B restarts it. While running, the counter drops by one per `tick_en` pulse. While halted, it holds its value.
- R3: A write of 0x0000AB00 to offset 0x00 opens the count. While the count is open, a write to offset 0x04 loads the counter with data bits [15:0] in counter bits [19:4] and zeros in bits [3:0]. A read of offset 0x04 returns counter bits [19:4] in bits [15:0] and zero above.
- R4: A write of 0x0000AB01 to offset 0x00 seals the count. While the count is sealed, writes to offset 0x04 leave the counter unchanged.
- R5: A write of 0x0000DEAF to offset 0x00 fills the counter with all ones, whether the count is open or sealed.
- R6: A write to offset 0x00 whose full 32-bit value matches none of the six command words changes nothing. This includes a command word with nonzero upper bits.
- R7: The counter floors at zero. If a tick arrives while the counter is running and holds 1 or 0, `wdt_irq` rises on the next cycle. It stays high until 0x00007482 is written to offset 0x00.
- R8: If `wdt_irq` is still high after 16 further ticks, `sys_rst_req` is high for exactly 32 clock cycles. After that the counter reads 0x0000FFFF and `wdt_irq` is low.
- R9: Acknowledging the interrupt before the 16-tick grace ends prevents the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle timebase pulse, one counter step |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset: 0x00 control, 0x04 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero unless reading 0x04 |
| wdt_irq | output | 1 | Sticky expiry interrupt |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The assertions take two things for granted. Each register access is a single-cycle strobe. Software traffic to the count location is limited to the two defined offsets, so a cycle with `bus_valid` low carries no command. The stimulus keeps within these limits. It drives one access at a time, each framed by `bus_valid` for exactly one cycle, and it fires `tick_en` as a one-cycle pulse on every fourth clock. This keeps the expiry and grace windows short while preserving their tick-based timing.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam logic [15:0] CMD_HALT = 16'h3877;
   localparam logic [15:0] CMD_RUN  = 16'h4A4B;
   localparam logic [15:0] CMD_ACK  = 16'h7482;
   localparam logic [15:0] CMD_OPEN = 16'hAB00;
   localparam logic [15:0] CMD_SEAL = 16'hAB01;
   localparam logic [15:0] CMD_FILL = 16'hDEAF;

   typedef struct packed {
      logic halt;
      logic run;
      logic ack;
      logic open;
      logic seal;
      logic fill;
   } wdg_cmd_t;
endpackage

// File: rtl/wdg_cmd_decode.sv
module wdg_cmd_decode
   import wdg_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic              cnt_we,
   input  logic [DATA_W-1:0] wdata,
   output wdg_cmd_t          cmd_o,
   output logic              run_o,
   output logic              open_o,
   output logic              load_o
);
   logic run_q, open_q;

   function automatic logic hit(input logic [DATA_W-1:0] d, input logic [15:0] code);
      return d == DATA_W'(code);
   endfunction

   always_comb begin
      cmd_o.halt = ctrl_we && hit(wdata, CMD_HALT);
      cmd_o.run  = ctrl_we && hit(wdata, CMD_RUN);
      cmd_o.ack  = ctrl_we && hit(wdata, CMD_ACK);
      cmd_o.open = ctrl_we && hit(wdata, CMD_OPEN);
      cmd_o.seal = ctrl_we && hit(wdata, CMD_SEAL);
      cmd_o.fill = ctrl_we && hit(wdata, CMD_FILL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         open_q <= 1'b0;
      end else begin
         if (cmd_o.halt)      run_q <= 1'b0;
         else if (cmd_o.run)  run_q <= 1'b1;
         if (cmd_o.open)      open_q <= 1'b1;
         else if (cmd_o.seal) open_q <= 1'b0;
      end
   end

   assign run_o  = run_q;
   assign open_o = open_q;
   assign load_o = cnt_we && open_q;

   AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_o)) else $error("decode hit two commands"); // R6
endmodule

// File: rtl/wdg_downcount.sv
module wdg_downcount #(
   parameter int CNT_W  = 20,
   parameter int VIEW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              run_i,
   input  logic              load_i,
   input  logic [VIEW_W-1:0] load_val_i,
   input  logic              fill_i,
   input  logic              reload_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              expire_o
);
   localparam int SHIFT = CNT_W - VIEW_W;
   logic [CNT_W-1:0] cnt_q;

   assign expire_o = run_i && tick_i && (cnt_q <= CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)                             cnt_q <= '1;
      else if (reload_i)                      cnt_q <= '1;
      else if (load_i)                        cnt_q <= {load_val_i, {SHIFT{1'b0}}};
      else if (fill_i)                        cnt_q <= '1;
      else if (run_i && tick_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
   end

   assign cnt_o = cnt_q;

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !fill_i && !reload_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)))
      else $error("counter jumped"); // R2
endmodule

// File: rtl/wdg_expiry.sv
module wdg_expiry #(
   parameter int GRACE_TICKS  = 16,
   parameter int PULSE_CYCLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic expire_i,
   input  logic ack_i,
   output logic irq_o,
   output logic pulse_o,
   output logic pulse_end_o
);
   localparam int GW = $clog2(GRACE_TICKS) + 1;
   localparam int PW = $clog2(PULSE_CYCLES) + 1;

   logic          irq_q, act_q;
   logic [GW-1:0] gcnt_q;
   logic [PW-1:0] pcnt_q;
   logic          grace_done;

   assign grace_done  = irq_q && tick_i && !act_q && gcnt_q == GW'(GRACE_TICKS - 1);
   assign pulse_end_o = act_q && pcnt_q == PW'(PULSE_CYCLES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         gcnt_q <= '0;
         act_q  <= 1'b0;
         pcnt_q <= '0;
      end else begin
         if (pulse_end_o || ack_i) irq_q <= 1'b0;
         else if (expire_i)        irq_q <= 1'b1;

         if (!irq_q || act_q) gcnt_q <= '0;
         else if (tick_i)     gcnt_q <= grace_done ? '0 : gcnt_q + GW'(1);

         if (grace_done) begin
            act_q  <= 1'b1;
            pcnt_q <= '0;
         end else if (pulse_end_o) begin
            act_q  <= 1'b0;
         end else if (act_q) begin
            pcnt_q <= pcnt_q + PW'(1);
         end
      end
   end

   assign irq_o   = irq_q;
   assign pulse_o = act_q;

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !ack_i && !pulse_end_o) |=> irq_q) else $error("irq dropped"); // R7
   AST_PULSE_FROM_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> $past(irq_q)) else $error("reset without irq"); // R8
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import wdg_pkg::*;
#(
   parameter int CNT_W        = 20,
   parameter int VIEW_W       = 16,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 8,
   parameter int GRACE_TICKS  = 16,
   parameter int PULSE_CYCLES = 32,
   parameter bit READ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdt_irq,
   output logic              sys_rst_req
);
   localparam int              SHIFT    = CNT_W - VIEW_W;
   localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] CNT_OFF  = ADDR_W'(4);

   initial begin
      AST_CFG_WIDTH: assert (CNT_W > VIEW_W && DATA_W >= VIEW_W && DATA_W >= 16)
         else $error("bad width parameters");
      AST_CFG_TIMES: assert (GRACE_TICKS >= 1 && PULSE_CYCLES >= 2)
         else $error("bad timing parameters");
   end

   logic             ctrl_we, cnt_we, running, unlocked, load_en, expire, pulse_end;
   wdg_cmd_t         cmd;
   logic [CNT_W-1:0] cnt;
   logic [DATA_W-1:0] rd_word;

   assign ctrl_we = bus_valid && bus_write && bus_addr == CTRL_OFF;
   assign cnt_we  = bus_valid && bus_write && bus_addr == CNT_OFF;

   wdg_cmd_decode #(.DATA_W(DATA_W)) u_decode (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .cnt_we(cnt_we),
      .wdata(bus_wdata), .cmd_o(cmd), .run_o(running), .open_o(unlocked), .load_o(load_en)
   );

   wdg_downcount #(.CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .run_i(running), .load_i(load_en),
      .load_val_i(bus_wdata[VIEW_W-1:0]), .fill_i(cmd.fill), .reload_i(pulse_end),
      .cnt_o(cnt), .expire_o(expire)
   );

   wdg_expiry #(.GRACE_TICKS(GRACE_TICKS), .PULSE_CYCLES(PULSE_CYCLES)) u_expiry (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .expire_i(expire), .ack_i(cmd.ack),
      .irq_o(wdt_irq), .pulse_o(sys_rst_req), .pulse_end_o(pulse_end)
   );

   assign rd_word = (bus_valid && !bus_write && bus_addr == CNT_OFF)
                    ? DATA_W'(cnt[CNT_W-1:SHIFT]) : '0;

   generate
      if (READ_REG) begin : g_rd_flop
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_word;
         end
         assign bus_rdata = rd_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_word;
      end
   endgenerate

   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !bus_valid && !pulse_end) |=> $stable(cnt)) else $error("count moved while halted"); // R2
   AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_we && !unlocked && !running && !pulse_end) |=> $stable(cnt)) else $error("sealed count written"); // R4
   AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt == '0 && !bus_valid && !pulse_end) |=> cnt == '0) else $error("count wrapped"); // R7
   AST_REFILL_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_end |=> (cnt == '1 && !wdt_irq && !sys_rst_req)) else $error("no refill after pulse"); // R8
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
   logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdt_irq, sys_rst_req;

   keyed_watchdog u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wdt_irq(wdt_irq), .sys_rst_req(sys_rst_req)
   );

   always #5 clk = ~clk;

   int checks = 0, fails = 0, phase = 0;
   bit tick_on = 1'b0;

   always @(negedge clk) begin
      phase   = (phase + 1) % 4;
      tick_en = tick_on && (phase == 0);
   end

   // behavioural reference model
   localparam int MAXC = 20'hFFFFF;
   int m_cnt = MAXC, m_g = 0, m_pc = 0;
   bit m_run, m_unl, m_irq, m_act;
   bit t_ctrl, t_cntw, t_exp, t_pend, t_gdone, t_ack;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = MAXC; m_run = 0; m_unl = 0; m_irq = 0; m_g = 0; m_act = 0; m_pc = 0;
      end else begin
         t_ctrl  = bus_valid && bus_write && bus_addr == 8'h00;
         t_cntw  = bus_valid && bus_write && bus_addr == 8'h04;
         t_ack   = t_ctrl && bus_wdata == 32'h7482;
         t_exp   = m_run && tick_en && m_cnt <= 1;
         t_pend  = m_act && m_pc == 31;
         t_gdone = m_irq && tick_en && !m_act && m_g == 15;
         if (!m_irq || m_act) m_g = 0;
         else if (tick_en)    m_g = t_gdone ? 0 : m_g + 1;
         if (t_gdone) begin m_act = 1; m_pc = 0; end
         else if (t_pend) m_act = 0;
         else if (m_act) m_pc = m_pc + 1;
         if (t_pend)                              m_cnt = MAXC;
         else if (t_cntw && m_unl)                m_cnt = int'(bus_wdata[15:0]) * 16;
         else if (t_ctrl && bus_wdata == 32'hDEAF) m_cnt = MAXC;
         else if (m_run && tick_en && m_cnt > 0)  m_cnt = m_cnt - 1;
         if (t_pend || t_ack) m_irq = 0;
         else if (t_exp)      m_irq = 1;
         if (t_ctrl && bus_wdata == 32'h3877) m_run = 0;
         if (t_ctrl && bus_wdata == 32'h4A4B) m_run = 1;
         if (t_ctrl && bus_wdata == 32'hAB00) m_unl = 1;
         if (t_ctrl && bus_wdata == 32'hAB01) m_unl = 0;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // compared on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         check("R7 irq vs model", {31'b0, wdt_irq}, {31'b0, m_irq});
         check("R8 rst vs model", {31'b0, sys_rst_req}, {31'b0, m_act});
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 0; bus_write = 0;
   endtask

   task automatic rd(output logic [31:0] v);
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_addr = 8'h04;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_valid = 0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired R1 actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v, v1;
      int n;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1;
      tick_on = 1;
      @(negedge clk);
      check("R1 irq after reset", {31'b0, wdt_irq}, 32'd0);
      check("R1 rst after reset", {31'b0, sys_rst_req}, 32'd0);
      rd(v); check("R1 count after reset", v, 32'h0000FFFF);
      repeat (40) @(negedge clk);
      rd(v); check("R2 halted after reset", v, 32'h0000FFFF);

      wr(8'h04, 32'h0123); rd(v); check("R4 sealed write ignored", v, 32'h0000FFFF);
      wr(8'h00, 32'hAB00); wr(8'h04, 32'hFFFF0123);
      rd(v); check("R3 open load view", v, 32'h00000123);
      wr(8'h00, 32'h12344A4B); wr(8'h00, 32'h00001111);
      repeat (40) @(negedge clk);
      rd(v); check("R6 unmatched words ignored", v, 32'h00000123);
      wr(8'h00, 32'hAB01); wr(8'h04, 32'h0456);
      rd(v); check("R4 sealed again", v, 32'h00000123);
      wr(8'h00, 32'hDEAF); rd(v); check("R5 fill while sealed", v, 32'h0000FFFF);

      wr(8'h00, 32'h4A4B);
      repeat (200) @(negedge clk);
      rd(v); check("R2 running count", v, 32'(m_cnt / 16));
      check("R2 count moved", {31'b0, v < 32'hFFFF}, 32'd1);
      wr(8'h00, 32'h3877); rd(v1);
      repeat (100) @(negedge clk);
      rd(v); check("R2 halt holds", v, v1);

      wr(8'h00, 32'hAB00); wr(8'h04, 32'h0001);
      rd(v); check("R3 load of one", v, 32'h00000001);
      wr(8'h00, 32'h4A4B);
      n = 0;
      while (!wdt_irq && n < 400) begin @(negedge clk); n++; end
      check("R7 irq raised", {31'b0, wdt_irq}, 32'd1);
      rd(v); check("R7 count floors", v, 32'h0);
      repeat (12) @(negedge clk);
      wr(8'h04, 32'h0100); wr(8'h00, 32'h7482);
      check("R7 ack clears irq", {31'b0, wdt_irq}, 32'd0);
      seen = 0;
      repeat (150) begin @(negedge clk); if (sys_rst_req) seen = 1; end
      check("R9 ack prevents reset", {31'b0, seen}, 32'd0);

      wr(8'h04, 32'h0001);
      n = 0;
      while (!sys_rst_req && n < 600) begin @(negedge clk); n++; end
      check("R8 reset asserted", {31'b0, sys_rst_req}, 32'd1);
      n = 0;
      while (sys_rst_req && n < 100) begin @(negedge clk); n++; end
      check("R8 pulse width", 32'(n), 32'd32);
      check("R8 irq dropped", {31'b0, wdt_irq}, 32'd0);
      wr(8'h00, 32'h3877);
      rd(v); check("R8 refilled", v, 32'h0000FFFF);

      summary();
      $finish;
   end
endmodule